// File: doc/BRIEF.md
# Received Stream Data Checker

This block watches one 32-bit receive data stream, one beat per clock, made of a valid strobe, an end-of-packet marker, a byte-enable lane mask and an 8-bit error code. It keeps a 48-bit count of the bytes received. It compares each beat with a 32-bit expected word that counts up by one per beat from an initial value chosen by the user.

When a packet ends with a nonzero error code, the block raises an error interrupt and keeps that code. On the first data mismatch it freezes a diagnostic record: the byte offset of the failing beat, the word it expected and the word it received. A start pulse arms a new test. A clear pulse drops the error latch.

Every output is registered. Each output shows the effect of a clock edge one cycle after that edge.

Top module: `rx_stream_checker`

## Requirements
- R1: The error code is sampled only on a beat where `rx_valid_i` and `rx_eop_i` are both high. A nonzero code on any other beat changes neither `err_irq_o` nor `err_code_o`.
- R2: A nonzero sampled code sets `err_irq_o` and loads `err_code_o` with that code on the next cycle. A later nonzero sampled code overwrites the stored code. A zero sampled code leaves both outputs unchanged.
- R3: On each valid beat, `byte_cnt_o` (48 bits) grows by the number of set bits in `rx_be_i`. Bit i of `rx_be_i` marks `rx_data_i[8i+7:8i]` as valid.
- R4: The expected word is loaded from `init_patt_i` on a start pulse. It then increases by one, modulo 2^32, after every valid beat.
- R5: `fail_o` rises the cycle after a valid beat on which `verify_en_i` is high and some enabled byte lane differs from the expected word. It stays high until the next start.
- R6: While `fail_o` is low, every valid beat records three values: the byte count held before that beat in `fail_pos_o`, the expected word in `fail_exp_o` and the raw received word in `fail_got_o`. Once a failure is recorded, these outputs stay frozen.
- R7: A clear pulse zeroes `err_irq_o` and `err_code_o`. A clear pulse wins over an error captured in the same cycle.
- R8: Byte lanes whose enable is 0 take no part in the comparison.
- R9: A start pulse zeroes the byte count, the fail flag and the three diagnostic outputs. A valid beat in the same cycle is ignored. A start pulse leaves the error latch unchanged.
- R10: After reset every output is zero, and the expected word is also zero.
- R11: With `verify_en_i` low, a mismatch never sets `fail_o`, and the diagnostic outputs keep tracking each beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arms a new test and loads the initial pattern |
| clear_i | input | 1 | Drops the error latch |
| verify_en_i | input | 1 | Enables data comparison |
| init_patt_i | input | 32 | Initial expected word |
| rx_valid_i | input | 1 | Beat valid |
| rx_eop_i | input | 1 | Last beat of a packet |
| rx_be_i | input | 4 | Byte-lane enables |
| rx_data_i | input | 32 | Beat data |
| rx_err_i | input | 8 | Packet error code, meaningful on the last beat only |
| byte_cnt_o | output | 48 | Received byte count |
| err_irq_o | output | 1 | Error interrupt flag |
| err_code_o | output | 8 | Latched error code |
| fail_o | output | 1 | Data mismatch flag |
| fail_pos_o | output | 48 | Byte offset of the failing beat |
| fail_exp_o | output | 32 | Expected word at the failure |
| fail_got_o | output | 32 | Received word at the failure |

## Verification
The bench builds the block with its default sizes: a 32-bit data path, four byte lanes, a 48-bit counter and an 8-bit error code. These sizes make lane-masked comparison on partial beats reachable. They also make the 32-bit wrap of the expected word reachable, by starting the pattern at all ones.

The 48-bit counter cannot wrap within the run. It is checked for exact growth per beat instead. A behavioural model runs beside the design and is compared on every cycle. Directed checks cover these cases:
- a start beat arriving together with a valid beat;
- a clear arriving together with an error capture;
- a failure record being frozen;
- comparison with verification turned off.

// File: rtl/rx_chk_pkg.sv
package rx_chk_pkg;
  localparam int unsigned LANE_BITS   = 8;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_CNT_W   = 48;
  localparam int unsigned DEF_ERR_W   = 8;
endpackage

// File: rtl/rx_byte_counter.sv
module rx_byte_counter #(
  parameter int unsigned BE_W  = 4,
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             beat_i,
  input  logic [BE_W-1:0]  be_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] add;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    add = '0;
    for (int i = 0; i < BE_W; i++) add = add + CNT_W'(be_i[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (beat_i)  cnt_q <= cnt_q + add;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rx_pattern_verifier.sv
module rx_pattern_verifier
  import rx_chk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 48,
  localparam int unsigned BE_W  = DATA_W / LANE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] init_i,
  input  logic              verify_en_i,
  input  logic              beat_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  pos_i,
  output logic              fail_o,
  output logic [CNT_W-1:0]  pos_o,
  output logic [DATA_W-1:0] exp_o,
  output logic [DATA_W-1:0] got_o
);
  logic [DATA_W-1:0] exp_q;
  logic [BE_W-1:0]   lane_bad;
  logic              mismatch;
  logic              fail_q;
  logic [CNT_W-1:0]  pos_q;
  logic [DATA_W-1:0] fexp_q;
  logic [DATA_W-1:0] fgot_q;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_bad[g] = be_i[g] &&
      (data_i[g*LANE_BITS +: LANE_BITS] != exp_q[g*LANE_BITS +: LANE_BITS]);
  end

  assign mismatch = verify_en_i && (|lane_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q  <= '0;
      fail_q <= 1'b0;
      pos_q  <= '0;
      fexp_q <= '0;
      fgot_q <= '0;
    end else if (start_i) begin
      exp_q  <= init_i;
      fail_q <= 1'b0;
      pos_q  <= '0;
      fexp_q <= '0;
      fgot_q <= '0;
    end else if (beat_i) begin
      exp_q <= exp_q + DATA_W'(1);
      if (!fail_q) begin
        pos_q  <= pos_i;
        fexp_q <= exp_q;
        fgot_q <= data_i;
      end
      fail_q <= fail_q | mismatch;
    end
  end

  assign fail_o = fail_q;
  assign pos_o  = pos_q;
  assign exp_o  = fexp_q;
  assign got_o  = fgot_q;
endmodule

// File: rtl/rx_error_latch.sv
module rx_error_latch #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic             eop_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             irq_o,
  output logic [ERR_W-1:0] code_o
);
  logic             irq_q;
  logic [ERR_W-1:0] code_q;
  logic             hit;

  assign hit = valid_i && eop_i && (err_i != '0);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      irq_q  <= 1'b0;
      code_q <= '0;
    end else if (hit) begin
      irq_q  <= 1'b1;
      code_q <= err_i;
    end
  end

  assign irq_o  = irq_q;
  assign code_o = code_q;
endmodule

// File: rtl/rx_stream_checker.sv
module rx_stream_checker
  import rx_chk_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned ERR_W  = DEF_ERR_W,
  localparam int unsigned BE_W  = DATA_W / LANE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic              verify_en_i,
  input  logic [DATA_W-1:0] init_patt_i,
  input  logic              rx_valid_i,
  input  logic              rx_eop_i,
  input  logic [BE_W-1:0]   rx_be_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              err_irq_o,
  output logic [ERR_W-1:0]  err_code_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  fail_pos_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o
);
  logic             beat;
  logic [CNT_W-1:0] cnt;

  assign beat = rx_valid_i && !start_i;

  rx_byte_counter #(.BE_W(BE_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start_i(start_i), .beat_i(beat),
    .be_i(rx_be_i), .cnt_o(cnt)
  );

  rx_pattern_verifier #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ver (
    .clk(clk), .rst(rst), .start_i(start_i), .init_i(init_patt_i),
    .verify_en_i(verify_en_i), .beat_i(beat), .be_i(rx_be_i),
    .data_i(rx_data_i), .pos_i(cnt), .fail_o(fail_o),
    .pos_o(fail_pos_o), .exp_o(fail_exp_o), .got_o(fail_got_o)
  );

  rx_error_latch #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .clear_i(clear_i), .valid_i(rx_valid_i),
    .eop_i(rx_eop_i), .err_i(rx_err_i), .irq_o(err_irq_o),
    .code_o(err_code_o)
  );

  assign byte_cnt_o = cnt;
endmodule

// File: rtl/rx_stream_checker_sva.sv
module rx_stream_checker_sva #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned ERR_W  = 8,
  parameter int unsigned BE_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              clear_i,
  input logic              rx_valid_i,
  input logic              rx_eop_i,
  input logic [BE_W-1:0]   rx_be_i,
  input logic [ERR_W-1:0]  rx_err_i,
  input logic [CNT_W-1:0]  byte_cnt_o,
  input logic              err_irq_o,
  input logic [ERR_W-1:0]  err_code_o,
  input logic              fail_o,
  input logic [CNT_W-1:0]  fail_pos_o,
  input logic [DATA_W-1:0] fail_exp_o,
  input logic [DATA_W-1:0] fail_got_o
);
  a_r1_err_only_at_eop: assert property (@(posedge clk) disable iff (rst)
    (!(rx_valid_i && rx_eop_i) && !clear_i) |=> ($stable(err_code_o) && $stable(err_irq_o)));

  a_r2_err_capture: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_i && rx_eop_i && (rx_err_i != '0) && !clear_i)
      |=> (err_irq_o && (err_code_o == $past(rx_err_i))));

  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_i && !start_i)
      |=> (byte_cnt_o == $past(byte_cnt_o) + CNT_W'($countones($past(rx_be_i)))));

  a_r3_count_idle: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid_i && !start_i) |=> $stable(byte_cnt_o));

  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !start_i) |=> fail_o);

  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !start_i)
      |=> ($stable(fail_pos_o) && $stable(fail_exp_o) && $stable(fail_got_o)));

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (!err_irq_o && (err_code_o == '0)));

  a_r9_start: assert property (@(posedge clk) disable iff (rst)
    start_i |=> ((byte_cnt_o == '0) && !fail_o && (fail_pos_o == '0)));
endmodule

bind rx_stream_checker rx_stream_checker_sva #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .ERR_W(ERR_W), .BE_W(BE_W)
) u_sva (
  .clk(clk), .rst(rst), .start_i(start_i), .clear_i(clear_i),
  .rx_valid_i(rx_valid_i), .rx_eop_i(rx_eop_i), .rx_be_i(rx_be_i),
  .rx_err_i(rx_err_i), .byte_cnt_o(byte_cnt_o), .err_irq_o(err_irq_o),
  .err_code_o(err_code_o), .fail_o(fail_o), .fail_pos_o(fail_pos_o),
  .fail_exp_o(fail_exp_o), .fail_got_o(fail_got_o)
);

// File: tb/rx_stream_checker_tb.sv
module rx_stream_checker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, clear_i = 1'b0, verify_en_i = 1'b0;
  logic [31:0] init_patt_i = '0;
  logic        rx_valid_i = 1'b0, rx_eop_i = 1'b0;
  logic [3:0]  rx_be_i = '0;
  logic [31:0] rx_data_i = '0;
  logic [7:0]  rx_err_i = '0;
  logic [47:0] byte_cnt_o;
  logic        err_irq_o;
  logic [7:0]  err_code_o;
  logic        fail_o;
  logic [47:0] fail_pos_o;
  logic [31:0] fail_exp_o, fail_got_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit armed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_stream_checker u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .clear_i(clear_i),
    .verify_en_i(verify_en_i), .init_patt_i(init_patt_i),
    .rx_valid_i(rx_valid_i), .rx_eop_i(rx_eop_i), .rx_be_i(rx_be_i),
    .rx_data_i(rx_data_i), .rx_err_i(rx_err_i), .byte_cnt_o(byte_cnt_o),
    .err_irq_o(err_irq_o), .err_code_o(err_code_o), .fail_o(fail_o),
    .fail_pos_o(fail_pos_o), .fail_exp_o(fail_exp_o), .fail_got_o(fail_got_o)
  );

  // behavioural reference model
  longint unsigned m_cnt, m_pos;
  int unsigned m_exp, m_fexp, m_fgot;
  bit m_irq, m_fail;
  int unsigned m_code;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pos = 0; m_exp = 0; m_fexp = 0; m_fgot = 0;
      m_irq = 0; m_fail = 0; m_code = 0;
    end else begin
      if (start_i) begin
        m_cnt = 0; m_exp = init_patt_i; m_fail = 0;
        m_pos = 0; m_fexp = 0; m_fgot = 0;
      end else if (rx_valid_i) begin
        int n; bit bad;
        n = 0; bad = 0;
        for (int i = 0; i < 4; i++)
          if (rx_be_i[i]) begin
            n++;
            if (rx_data_i[8*i +: 8] != m_exp[8*i +: 8]) bad = 1;
          end
        if (!m_fail) begin m_pos = m_cnt; m_fexp = m_exp; m_fgot = rx_data_i; end
        if (verify_en_i && bad) m_fail = 1;
        m_cnt = m_cnt + n;
        m_exp = m_exp + 1;
      end
      if (clear_i) begin m_irq = 0; m_code = 0; end
      else if (rx_valid_i && rx_eop_i && rx_err_i != 0) begin m_irq = 1; m_code = rx_err_i; end
    end
  end

  task automatic chk(string tag, longint unsigned got, longint unsigned exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk("R3 model byte count", byte_cnt_o, m_cnt);
      chk("R2 model irq", err_irq_o, m_irq);
      chk("R2 model code", err_code_o, m_code);
      chk("R5 model fail", fail_o, m_fail);
      chk("R6 model pos", fail_pos_o, m_pos);
      chk("R6 model exp", fail_exp_o, m_fexp);
      chk("R6 model got", fail_got_o, m_fgot);
    end
  end

  task automatic cyc(bit st, bit clr, bit v, bit eop, logic [3:0] be,
                     logic [31:0] d, logic [7:0] e);
    start_i = st; clear_i = clr; rx_valid_i = v; rx_eop_i = eop;
    rx_be_i = be; rx_data_i = d; rx_err_i = e;
    @(negedge clk);
    start_i = 0; clear_i = 0; rx_valid_i = 0; rx_eop_i = 0;
    rx_be_i = 0; rx_data_i = 0; rx_err_i = 0;
  endtask

  task automatic beat(logic [31:0] d);
    cyc(0, 0, 1, 0, 4'hF, d, 8'h00);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0; armed = 1;
    @(negedge clk);
    chk("R10 reset count", byte_cnt_o, 0);
    chk("R10 reset irq", err_irq_o, 0);
    chk("R10 reset fail", fail_o, 0);
    chk("R10 reset exp", fail_exp_o, 0);

    verify_en_i = 1; init_patt_i = 32'h1000_0000;
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R9 start count", byte_cnt_o, 0);
    for (int k = 0; k < 4; k++) beat(32'h1000_0000 + k);
    chk("R3 count after four full beats", byte_cnt_o, 16);
    chk("R4 expected word tracked", fail_exp_o, 32'h1000_0003);
    chk("R6 position tracked", fail_pos_o, 12);
    chk("R5 no fail on match", fail_o, 0);

    cyc(0, 0, 1, 0, 4'b0001, 32'hABCD_EF04, 0);
    chk("R8 masked lanes ignored", fail_o, 0);
    chk("R3 partial beat count", byte_cnt_o, 17);

    cyc(0, 0, 1, 0, 4'hF, 32'h1000_0005, 8'h55);
    chk("R1 code ignored off eop", err_irq_o, 0);
    cyc(0, 0, 1, 1, 4'hF, 32'h1000_0006, 8'h21);
    chk("R2 irq set", err_irq_o, 1);
    chk("R2 code latched", err_code_o, 8'h21);
    cyc(0, 0, 1, 1, 4'hF, 32'h1000_0007, 8'h00);
    chk("R2 zero code keeps latch", err_code_o, 8'h21);
    cyc(0, 0, 1, 1, 4'hF, 32'h1000_0008, 8'h7E);
    chk("R2 code overwritten", err_code_o, 8'h7E);

    cyc(0, 1, 0, 0, 0, 0, 0);
    chk("R7 clear irq", err_irq_o, 0);
    chk("R7 clear code", err_code_o, 0);
    cyc(0, 1, 1, 1, 4'hF, 32'h1000_0009, 8'h33);
    chk("R7 clear beats capture", err_irq_o, 0);
    chk("R3 count", byte_cnt_o, 37);

    beat(32'hDEAD_BEEF);
    chk("R5 fail set", fail_o, 1);
    chk("R6 fail pos", fail_pos_o, 37);
    chk("R6 fail exp", fail_exp_o, 32'h1000_000A);
    chk("R6 fail got", fail_got_o, 32'hDEAD_BEEF);
    beat(32'h1000_000B);
    beat(32'h0000_0000);
    chk("R6 pos frozen", fail_pos_o, 37);
    chk("R6 exp frozen", fail_exp_o, 32'h1000_000A);
    chk("R5 fail sticky", fail_o, 1);

    cyc(0, 0, 1, 1, 4'hF, 32'h0, 8'h44);
    init_patt_i = 32'h0000_0500;
    cyc(1, 0, 1, 1, 4'hF, 32'h1234_5678, 8'h00);
    chk("R9 start zeroes count and drops beat", byte_cnt_o, 0);
    chk("R9 start clears fail", fail_o, 0);
    chk("R9 start clears pos", fail_pos_o, 0);
    chk("R9 start keeps irq", err_irq_o, 1);
    chk("R9 start keeps code", err_code_o, 8'h44);

    verify_en_i = 0;
    beat(32'h0000_0000);
    chk("R11 no fail when disabled", fail_o, 0);
    chk("R11 exp still tracked", fail_exp_o, 32'h0000_0500);
    chk("R11 got still tracked", fail_got_o, 0);

    verify_en_i = 1; init_patt_i = 32'hFFFF_FFFF;
    cyc(1, 0, 0, 0, 0, 0, 0);
    beat(32'hFFFF_FFFF); beat(32'h0000_0000); beat(32'h0000_0001);
    chk("R4 wrap no fail", fail_o, 0);
    chk("R4 wrap expected", fail_exp_o, 32'h0000_0001);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule